// File: doc/BRIEF.md
# DMA Request Qualification Front End

This block sits at the front of a four-channel DMA controller. It decides which channels are asking for service. Each channel has a request line whose active level is set by a configuration input. Every line passes through a two-flop synchroniser. The synchronised electrical level, not the logical one, is stored in the upper half of an eight-bit status word. The stored level is converted to a logical request only where it is used: in the status read data and in the qualified request vector. Because of this, the polarity input can change without any resampling, and a controller reset has no need to touch the line history.

A four-bit mask register gates each channel. The processor changes it through three write targets: a single-channel set/clear, a clear-all, and a full load. The lower half of the status word holds one sticky terminal-count flag per channel. A per-channel pulse sets the flag. A normal status read clears it. A debug read returns the same data and leaves the flags alone. A power-on reset puts every register in a known idle state. A separate controller reset restores the mask and flags but keeps the line levels.

Top module: `dreq_front`

## Requirements
- R1: After the power-on reset `por_n` is released, the mask is 4'hF, `rd_data` reads 8'h00 and `req_active_o` is 0, whichever polarity is configured. The stored line levels start at the inactive level: all ones when `cfg_active_low`=1 and all zeros when it is 0.
- R2: `rd_data[4+n]` gives the logical request of channel n, where 1 means requesting. It follows a change on `dreq_i[n]` on the third rising clock edge after the change: two synchroniser stages, then the status register.
- R3: `req_active_o[n]` is 1 exactly when channel n's logical request is 1 and mask bit n is 0.
- R4: A write with `wr_sel`=2'b00 selects the channel given by `wr_data[1:0]`. That channel's mask bit becomes `wr_data[2]`, where 1 masks and 0 unmasks. The other mask bits are unchanged.
- R5: A write with `wr_sel`=2'b01 clears all four mask bits.
- R6: A write with `wr_sel`=2'b10 loads `wr_data[3:0]` into the mask and leaves the status word unchanged. A write with `wr_sel`=2'b11 changes nothing.
- R7: A pulse on `tc_pulse_i[n]` sets `rd_data[n]`, and the bit stays set until it is cleared.
- R8: A read (`rd_en`=1, `rd_debug`=0) clears `rd_data[3:0]` on that clock edge and leaves `rd_data[7:4]` unchanged.
- R9: A debug read (`rd_en`=1, `rd_debug`=1) leaves `rd_data[3:0]` unchanged.
- R10: A terminal-count pulse in the same cycle as a clearing read leaves that channel's flag set.
- R11: A controller reset (`soft_rst`=1) sets the mask to 4'hF and clears `rd_data[3:0]`. It keeps the stored line levels, so `rd_data[7:4]` still shows an active request right after the reset.
- R12: `cfg_active_low` acts at once on the stored levels. With it set to 1, a low line reads as requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous controller reset, active high |
| cfg_active_low | input | 1 | 1: request lines are active low |
| dreq_i | input | 4 | Raw request lines, one per channel |
| tc_pulse_i | input | 4 | Terminal-count pulses, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 single mask, 01 clear mask, 10 full mask, 11 none |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Status read strobe |
| rd_debug | input | 1 | Marks the read as side-effect free |
| rd_data | output | 8 | Status: [7:4] logical requests, [3:0] terminal-count flags |
| req_active_o | output | 4 | Qualified active requests |

## Verification
The request lines are driven with a checkerboard pattern, with all lines idle and with all lines asserted, first under active-high and then under active-low polarity. This separates a correct polarity conversion from a missing or double inversion. The status is sampled on the second and on the third edge after a line change, so a synchroniser that is one stage too short or too long is caught. Each mask write target is applied to a known mask, and the result is read through the qualified request vector while the status word is watched for changes it must not show. Terminal-count pulses are combined with debug reads, clearing reads, a read in the same cycle as a pulse, and a controller reset. These cases separate set priority, clear gating and reset scope.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_MASK_ONE = 2'b00,
        SEL_MASK_CLR = 2'b01,
        SEL_MASK_ALL = 2'b10,
        SEL_NONE     = 2'b11
    } wr_sel_e;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           init_lvl,
    input  logic [NCH-1:0] d_i,
    output logic [NCH-1:0] q_o
);

    typedef struct packed {
        logic [NCH-1:0] s1;
        logic [NCH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NCH; i++) begin
            st_d.s1[i] = d_i[i];
            st_d.s2[i] = st_q.s1[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.s1 <= {NCH{init_lvl}};
            st_q.s2 <= {NCH{init_lvl}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

    AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!por_n)
        por_n && $past(por_n) |=> q_o == $past(d_i, 2)) else $error("sync depth"); // R2

endmodule

// File: rtl/dreq_mask_reg.sv
module dreq_mask_reg
    import dreq_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [NCH-1:0] mask_o
);

    localparam int unsigned CH_W = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;
    wr_sel_e  sel;
    logic     wr_data_unused;

    assign sel            = wr_sel_e'(wr_sel);
    assign wr_data_unused = ^wr_data[DW-1:NCH];

    always_comb begin
        st_d = st_q;
        if (soft_rst) begin
            st_d.mask = '1;
        end else if (wr_en) begin
            case (sel)
                SEL_MASK_ONE: st_d.mask[wr_data[CH_W-1:0]] = wr_data[CH_W];
                SEL_MASK_CLR: st_d.mask = '0;
                SEL_MASK_ALL: st_d.mask = wr_data[NCH-1:0];
                default:      st_d.mask = st_q.mask;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q.mask <= '1;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    AST_MASK_RESET: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> mask_o == '1) else $error("mask reset"); // R11
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && wr_en && wr_sel == 2'b01) |=> mask_o == '0) else $error("mask clear"); // R5
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && wr_en && wr_sel == 2'b10) |=> mask_o == $past(wr_data[NCH-1:0])) else $error("mask load"); // R6
    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && (!wr_en || wr_sel == 2'b11)) |=> $stable(mask_o)) else $error("mask idle"); // R6

endmodule

// File: rtl/dreq_status_reg.sv
module dreq_status_reg #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           soft_rst,
    input  logic           init_lvl,
    input  logic [NCH-1:0] line_i,
    input  logic [NCH-1:0] tc_i,
    input  logic           rd_en,
    input  logic           rd_dbg,
    output logic [NCH-1:0] line_o,
    output logic [NCH-1:0] tc_o
);

    typedef struct packed {
        logic [NCH-1:0] line;
        logic [NCH-1:0] tc;
    } stat_t;

    stat_t st_d, st_q;
    logic  rd_clear;

    assign rd_clear = rd_en && !rd_dbg;

    always_comb begin
        st_d      = st_q;
        st_d.line = line_i;
        if (soft_rst) begin
            st_d.tc = '0;
        end else begin
            st_d.tc = (rd_clear ? '0 : st_q.tc) | tc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q.line <= {NCH{init_lvl}};
            st_q.tc   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
    assign tc_o   = st_q.tc;

    AST_TC_SET: assert property (@(posedge clk) disable iff (!por_n)
        !soft_rst |=> (tc_o & $past(tc_i)) == $past(tc_i)) else $error("tc set"); // R10
    AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && rd_en && !rd_dbg) |=> tc_o == $past(tc_i)) else $error("tc clear"); // R8
    AST_TC_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!soft_rst && !(rd_en && !rd_dbg)) |=> (tc_o & $past(tc_o)) == $past(tc_o)) else $error("tc hold"); // R9
    AST_RST_TC: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> tc_o == '0) else $error("reset tc"); // R11
    AST_LINE_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        soft_rst |=> line_o == $past(line_i)) else $error("line keep"); // R11

endmodule

// File: rtl/dreq_front.sv
module dreq_front
    import dreq_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       soft_rst,
    input  logic       cfg_active_low,
    input  logic [3:0] dreq_i,
    input  logic [3:0] tc_pulse_i,
    input  logic       wr_en,
    input  logic [1:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic       rd_debug,
    output logic [7:0] rd_data,
    output logic [3:0] req_active_o
);

    localparam int unsigned NCH = NUM_CH;

    logic [NCH-1:0] line_sync;
    logic [NCH-1:0] line_q;
    logic [NCH-1:0] tc_q;
    logic [NCH-1:0] mask_q;
    logic [NCH-1:0] req_logic;

    dreq_sync #(.NCH(NCH)) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .init_lvl (cfg_active_low),
        .d_i      (dreq_i),
        .q_o      (line_sync)
    );

    dreq_status_reg #(.NCH(NCH)) u_status (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .init_lvl (cfg_active_low),
        .line_i   (line_sync),
        .tc_i     (tc_pulse_i),
        .rd_en    (rd_en),
        .rd_dbg   (rd_debug),
        .line_o   (line_q),
        .tc_o     (tc_q)
    );

    dreq_mask_reg #(.NCH(NCH), .DW(DATA_W)) u_mask (
        .clk      (clk),
        .por_n    (por_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .mask_o   (mask_q)
    );

    always_comb begin
        req_logic    = line_q ^ {NCH{cfg_active_low}};
        rd_data      = {req_logic, tc_q};
        req_active_o = req_logic & ~mask_q;
    end

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (!por_n)
        (req_active_o & mask_q) == '0) else $error("masked request"); // R3
    AST_REQ_FROM_STATUS: assert property (@(posedge clk) disable iff (!por_n)
        (req_active_o & ~rd_data[7:4]) == '0) else $error("request without status"); // R3

endmodule

// File: tb/dreq_front_tb.sv
`timescale 1ns/1ps
module dreq_front_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       cfg_active_low = 1'b0;
    logic [3:0] dreq_i = 4'h0;
    logic [3:0] tc_pulse_i = 4'h0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'b11;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic       rd_debug = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] req_active_o;

    always #2.5 clk = ~clk;

    dreq_front u_dut (
        .clk(clk), .por_n(por_n), .soft_rst(soft_rst), .cfg_active_low(cfg_active_low),
        .dreq_i(dreq_i), .tc_pulse_i(tc_pulse_i), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_en(rd_en), .rd_debug(rd_debug),
        .rd_data(rd_data), .req_active_o(req_active_o)
    );

    typedef struct {
        string      tag;
        logic [7:0] rd;
        logic [3:0] req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    task automatic expect_now(input string tag, input logic [7:0] rd, input logic [3:0] req);
        exp_t e;
        e.tag = tag; e.rd = rd; e.req = req;
        exp_q.push_back(e);
        #0.1;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            wait (exp_q.size() > 0);
            e = exp_q.pop_front();
            n_cmp++;
            if (rd_data !== e.rd || req_active_o !== e.req) begin
                n_bad++;
                $display("FAIL %s: rd_data=%h req=%b expected rd_data=%h req=%b",
                         e.tag, rd_data, req_active_o, e.rd, e.req);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [7:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        tick(1);
        wr_en = 1'b0; wr_sel = 2'b11; wr_data = 8'h00;
    endtask

    task automatic finish_run();
        wait (exp_q.size() == 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            finish_run();
        end
    end

    initial begin : driver
        tick(3);
        por_n = 1'b1;
        tick(1);
        expect_now("R1 power-up active-high", 8'h00, 4'h0);

        dreq_i = 4'b0101;
        tick(2);
        expect_now("R2 two edges no change yet", 8'h00, 4'h0);
        tick(1);
        expect_now("R2 third edge shows lines, R3 masked", 8'h50, 4'h0);

        write_reg(2'b01, 8'h00);
        expect_now("R5 clear mask", 8'h50, 4'b0101);
        write_reg(2'b00, 8'b0000_0110);
        expect_now("R4 single mask set ch2", 8'h50, 4'b0001);
        write_reg(2'b00, 8'b0000_0010);
        expect_now("R4 single mask clear ch2", 8'h50, 4'b0101);
        write_reg(2'b10, 8'hF1);
        expect_now("R6 full mask load, status kept", 8'h50, 4'b0100);
        write_reg(2'b11, 8'h0F);
        expect_now("R6 no-target write ignored", 8'h50, 4'b0100);

        tc_pulse_i = 4'b1001;
        tick(1);
        tc_pulse_i = 4'h0;
        expect_now("R7 tc flags set", 8'h59, 4'b0100);
        tick(2);
        expect_now("R7 tc flags held", 8'h59, 4'b0100);

        rd_en = 1'b1; rd_debug = 1'b1;
        tick(1);
        rd_en = 1'b0; rd_debug = 1'b0;
        expect_now("R9 debug read keeps tc", 8'h59, 4'b0100);

        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        expect_now("R8 read clears tc keeps lines", 8'h50, 4'b0100);

        rd_en = 1'b1; tc_pulse_i = 4'b0010;
        tick(1);
        rd_en = 1'b0; tc_pulse_i = 4'h0;
        expect_now("R10 set wins over read clear", 8'h52, 4'b0100);
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        expect_now("R8 later read clears", 8'h50, 4'b0100);

        tc_pulse_i = 4'b0100;
        tick(1);
        tc_pulse_i = 4'h0;
        expect_now("R7 tc ch2", 8'h54, 4'b0100);
        soft_rst = 1'b1;
        tick(1);
        soft_rst = 1'b0;
        expect_now("R11 reset keeps lines, mask all, tc clear", 8'h50, 4'h0);

        write_reg(2'b01, 8'h00);
        cfg_active_low = 1'b1;
        #0.5;
        expect_now("R12 polarity flips stored levels", 8'hA0, 4'b1010);
        tick(1);
        dreq_i = 4'hF;
        tick(3);
        expect_now("R12 idle-high lines read inactive", 8'h00, 4'h0);
        dreq_i = 4'h0;
        tick(3);
        expect_now("R12 low lines read requesting", 8'hF0, 4'hF);

        por_n = 1'b0;
        tick(3);
        por_n = 1'b1;
        tick(1);
        expect_now("R1 power-up active-low idle", 8'h00, 4'h0);
        tick(2);
        expect_now("R2 active-low lines after sync", 8'hF0, 4'h0);

        done = 1'b1;
        finish_run();
    end

endmodule